// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array word address for each cycle of a four-beat burst in a synchronous SRAM. On a load cycle with the device selected, it captures an external start address and the access type (read or write). On each following advance cycle, it steps a beat counter. The two least significant address bits are then derived from the start value and the beat count. A static order input chooses how they are derived: additive wrap-around (linear) or bitwise XOR (interleaved).

The upper address bits stay fixed for the whole burst. Advances beyond the fourth beat keep wrapping inside the same four-word block. A load cycle taken while the device is not selected ends the burst. The stall input freezes every register, so a stalled edge acts as if the clock edge had not occurred.

The outputs come straight from registers plus the order mapping. A load or advance presented before an edge is visible on `addr_out` after that edge.

Top module: `bsq_burst_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, with no load yet, `burst_on` = 0, `wr_out` = 0 and `addr_out` = 0.
- R2: An unstalled edge with `adv` = 0 and `sel_ok` = 1 is a load. After that edge, `addr_out` equals `addr_in`, `burst_on` = 1 and `wr_out` equals `wr_in`.
- R3: With `order_ilv` = 0, the k-th advance after a load gives `addr_out[1:0]` = (start + k) mod 4, where start is `addr_in[1:0]` at the load.
- R4: With `order_ilv` = 1, the k-th advance after a load gives `addr_out[1:0]` = start XOR (k mod 4).
- R5: During advances, `addr_out[ADDR_W-1:2]` never changes. Advances past the fourth beat continue the same mod-4 sequence.
- R6: On an advance edge (`adv` = 1), `addr_in` is ignored.
- R7: An unstalled edge with `adv` = 0 and `sel_ok` = 0 sets `burst_on` to 0 and leaves `addr_out` unchanged.
- R8: An edge with `stall` = 1 leaves `addr_out`, `burst_on` and `wr_out` unchanged, whatever the other inputs are.
- R9: `wr_out` keeps the type captured at the load for the whole burst. `wr_in` is ignored on advance edges.
- R10: An advance edge while `burst_on` = 0 leaves `addr_out` and `burst_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1 freezes all state for this edge |
| adv | input | 1 | 1 = advance the burst, 0 = load (or end the burst if not selected) |
| sel_ok | input | 1 | Combined chip-select result, 1 = selected |
| wr_in | input | 1 | Access type presented with a load, 1 = write |
| order_ilv | input | 1 | Static burst order, 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array word address |
| burst_on | output | 1 | A burst is in progress |
| wr_out | output | 1 | Access type of the current burst |

## Verification
Several properties are checked by assertions on every cycle:
- a stalled edge freezes all outputs;
- an advance keeps the upper address and the access type;
- a selected load shows the captured address on the next cycle;
- a deselected load clears the burst flag;
- the beat counter steps by one.

The actual beat sequence of each order can only be shown by the bench's sweep over every start offset, both orders and both access types, with six advances per burst. The same holds for the mod-4 wrap past the fourth beat and for the return of a frozen burst to its sequence once a stall ends.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2,
    OP_KILL = 2'd3
  } bsq_op_e;
endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stall,
  input  logic    adv,
  input  logic    sel_ok,
  input  logic    wr_in,
  output bsq_op_e op,
  output logic    active_q,
  output logic    wr_q
);
  logic active_d;
  logic wr_d;

  always_comb begin
    if (stall)       op = OP_HOLD;
    else if (!adv)   op = sel_ok ? OP_LOAD : OP_KILL;
    else if (active_q) op = OP_STEP;
    else             op = OP_HOLD;
  end

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    case (op)
      OP_LOAD: begin
        active_d = 1'b1;
        wr_d     = wr_in;
      end
      OP_KILL: active_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
    end
  end

  // R9: the access type survives every advance
  a_r9_wr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> (wr_q == $past(wr_q)));
  // R10: an advance never starts a burst
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && !active_q) |=> !active_q);
endmodule

// File: rtl/bsq_beat_cnt.sv
module bsq_beat_cnt
  import bsq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsq_op_e           op,
  output logic [BEAT_W-1:0] cnt_q
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);
  logic [BEAT_W-1:0] cnt_d;

  always_comb begin
    case (op)
      OP_LOAD: cnt_d = '0;
      OP_STEP: cnt_d = cnt_q + ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: one step per advance, wrapping modulo the burst length
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_val;
  logic [BEAT_W-1:0] xor_val;

  assign lin_val = start + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_val[i] = start[i] ^ beat[i];
  end

  assign low = ilv ? xor_val : lin_val;
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              wr_in,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_on,
  output logic              wr_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  bsq_op_e           op;
  logic              active_q;
  logic              wr_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] low;

  bsq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .adv      (adv),
    .sel_ok   (sel_ok),
    .wr_in    (wr_in),
    .op       (op),
    .active_q (active_q),
    .wr_q     (wr_q)
  );

  bsq_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .cnt_q (beat_q)
  );

  always_comb begin
    base_d = (op == OP_LOAD) ? addr_in : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  bsq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (base_q[BEAT_W-1:0]),
    .beat  (beat_q),
    .ilv   (order_ilv),
    .low   (low)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};
  assign burst_on = active_q;
  assign wr_out   = wr_q;

  // R2: a selected load shows the presented address next cycle
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel_ok) |=> (burst_on && addr_out == $past(addr_in)));
  // R5: upper bits fixed during advances
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));
  // R7: deselected load ends the burst, address held
  a_r7_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel_ok) |=> (!burst_on && $stable(addr_out)));
  // R8: stall freezes every output
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(addr_out) && $stable(burst_on) && $stable(wr_out)));
  // R10: idle advance changes nothing
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && !burst_on) |=> $stable(addr_out));
  // R1: reset state
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |-> (!burst_on && !wr_out && addr_out == '0));
endmodule

// File: tb/tb_bsq_burst_seq.sv
`timescale 1ns/1ps
module tb_bsq_burst_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall, adv, sel_ok, wr_in, order_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          burst_on, wr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bsq_burst_seq #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .sel_ok(sel_ok),
    .wr_in(wr_in), .order_ilv(order_ilv), .addr_in(addr_in),
    .addr_out(addr_out), .burst_on(burst_on), .wr_out(wr_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic a, input logic sel,
                     input logic w, input logic [AW-1:0] ad);
    stall = s; adv = a; sel_ok = sel; wr_in = w; addr_in = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] lowexp(input logic ilv, input logic [1:0] st, input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return ilv ? (st ^ kk) : 2'((int'(st) + k) % 4);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] held;
    rst_n = 1'b0; stall = 0; adv = 1; sel_ok = 1; wr_in = 0; order_ilv = 0; addr_in = '1;
    repeat (3) @(negedge clk);
    chk("R1 burst_on", 32'(burst_on), 0);
    chk("R1 addr_out", 32'(addr_out), 0);
    chk("R1 wr_out", 32'(wr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: advance with nothing loaded
    cyc(0, 1, 1, 1, 18'h2AAAA);
    chk("R10 addr idle", 32'(addr_out), 0);
    chk("R10 burst idle", 32'(burst_on), 0);

    // R3 R4 R5 R6 R9 sweep
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          logic [15:0] up;
          up = 16'((o * 8 + s * 2 + w) * 1237 + 5);
          order_ilv = o[0];
          @(negedge clk);
          cyc(0, 0, 1, w[0], {up, 2'(s)});
          chk("R2 addr", 32'(addr_out), 32'({up, 2'(s)}));
          chk("R2 burst_on", 32'(burst_on), 1);
          chk("R2 wr", 32'(wr_out), 32'(w));
          for (int k = 1; k <= 6; k++) begin
            cyc(0, 1, 1, ~w[0], ~{up, 2'(s)});
            chk(o ? "R4 interleaved beat" : "R3 linear beat",
                32'(addr_out[1:0]), 32'(lowexp(o[0], 2'(s), k)));
            chk("R5 R6 upper", 32'(addr_out[AW-1:2]), 32'(up));
            chk("R9 wr kept", 32'(wr_out), 32'(w));
          end
        end
      end
    end

    // R8: stall freezes, then sequence resumes
    order_ilv = 0;
    @(negedge clk);
    cyc(0, 0, 1, 1, 18'h12341);
    cyc(0, 1, 1, 0, 18'h0);
    held = addr_out;
    chk("R3 first beat", 32'(held), 32'h12342);
    cyc(1, 0, 1, 0, 18'h3FFFF);
    cyc(1, 0, 0, 0, 18'h0);
    cyc(1, 1, 1, 0, 18'h0);
    chk("R8 addr frozen", 32'(addr_out), 32'(held));
    chk("R8 burst frozen", 32'(burst_on), 1);
    chk("R8 wr frozen", 32'(wr_out), 1);
    cyc(0, 1, 1, 0, 18'h0);
    chk("R8 resume", 32'(addr_out), 32'h12343);

    // R7: deselect load ends burst, then advances do nothing
    held = addr_out;
    cyc(0, 0, 0, 0, 18'h00007);
    chk("R7 burst ended", 32'(burst_on), 0);
    chk("R7 addr held", 32'(addr_out), 32'(held));
    cyc(0, 1, 1, 0, 18'h00007);
    chk("R10 after kill", 32'(addr_out), 32'(held));
    chk("R10 stays idle", 32'(burst_on), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule